// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave

This block is the target side of a two-wire serial byte memory. Both bus lines are oversampled in the system clock domain. A transfer opens with a START. The first byte selects a device. It carries a fixed four-bit type code, three enable or upper-address bits and a direction bit. When the code matches the block's type and its strapped enable inputs, the block acknowledges. A write then takes one address byte and any number of data bytes. These bytes collect in a one-page staging buffer, and they reach the register array only when the master ends the transfer with a STOP.

A density parameter sets how many of the three enable bits act as upper memory address bits. An enable bit that does so is left out of the compare. A write-protect input lets the select and address bytes through with an acknowledge, then refuses every data byte. A minimal read path returns bytes from the address pointer. The line driver is open-drain: one output enable pulls the data line low.

Top module: `serial_mem_slave`

## Requirements
- R1: During and after reset the data-line pull-down `sdaOe` is off and the slave stays silent until a START.
- R2: A START is a fall of SDA while SCL is high, and a STOP is a rise of SDA while SCL is high. Data bits are sampled on SCL rising edges, MSB first, and `sdaOe` is released once a STOP is seen.
- R3: The select byte is accepted only if its bits 7:4 equal 4'b1010. Otherwise the slave gives no acknowledge and stays silent for the rest of the transfer.
- R4: Select bit k+1 (k = 0..2) is compared with `chipEn[k]` only when k >= HI_BITS. For k < HI_BITS that bit is excluded from the compare and becomes memory address bit 8+k.
- R5: The slave acknowledges a byte by asserting `sdaOe` from the SCL fall after the eighth bit until the SCL fall that ends the ninth clock.
- R6: After a matching select, the address byte is acknowledged whatever the level of `wcIn`.
- R7: While `wcIn` is high, every data byte is not acknowledged and the array is left unchanged.
- R8: Each accepted data byte advances the low PAGE_BITS address bits, wrapping inside the page, while the upper address bits stay fixed. A later byte at the same offset replaces an earlier one.
- R9: Staged bytes are written to the array only at a STOP that follows at least one acknowledged data byte. A repeated START, or a STOP with nothing accepted, discards them.
- R10: A select with bit 0 = 1 makes the slave send the byte at the address pointer MSB first. The pointer then increments across the whole array, and the slave sends the next byte after each master acknowledge until the master does not acknowledge.
- R11: `sdaOe` changes only in the cycle after a detected SCL fall, START or STOP, so the slave never moves SDA while SCL is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rstN | input | 1 | Active-low synchronous reset |
| sclIn | input | 1 | Bus clock line as seen at the pad |
| sdaIn | input | 1 | Bus data line as seen at the pad |
| chipEn | input | 3 | Strapped enable code compared with select bits 3:1 |
| wcIn | input | 1 | Write protect, high blocks data writes |
| sdaOe | output | 1 | Open-drain pull-down enable for the data line |

## Verification
The bench builds two copies on separate data lines with one shared clock line. One copy has HI_BITS = 0 and enable code 101, so all three select bits must match. The other has HI_BITS = 2 and enable code 110, so only the top select bit is compared and the two lower bits choose between distinct 256-byte banks. Both copies use PAGE_BITS = 4, so an 18-byte burst starting two bytes before a page boundary wraps and overwrites. The byte just past the page then shows that the upper bits stayed fixed.

// File: rtl/sms_pkg.sv
package sms_pkg;

  localparam logic [3:0] TYPE_ID = 4'b1010;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEL,
    ST_ADDR,
    ST_DATA,
    ST_READ,
    ST_SKIP
  } state_t;

  // Strobes from the protocol control to the datapath, one cycle each.
  typedef struct packed {
    logic driveAck;  // pull SDA low for an acknowledge slot
    logic letGo;     // release SDA
    logic loadTx;    // fetch byte at pointer, drive its MSB, bump pointer
    logic shiftTx;   // drive next transmit bit
    logic loadHi;    // take upper address bits from the select byte
    logic loadLo;    // take low address byte
    logic stage;     // place received byte in the page buffer
    logic commit;    // copy staged bytes into the array
    logic discard;   // drop staged bytes
  } strobe_t;

endpackage

// File: rtl/sms_datapath.sv
module sms_datapath
  import sms_pkg::*;
#(
  parameter int HI_BITS     = 0,
  parameter int PAGE_BITS   = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [2:0] chipEn,
  input  strobe_t    strb,
  output logic       evStart,
  output logic       evStop,
  output logic       evRise,
  output logic       evFall,
  output logic       sdaNow,
  output logic       rwBit,
  output logic       selMatch,
  output logic       sdaOe
);

  localparam int ADDR_W   = 8 + HI_BITS;
  localparam int DEPTH    = 1 << ADDR_W;
  localparam int PAGE_LEN = 1 << PAGE_BITS;
  localparam int TOP_W    = ADDR_W - PAGE_BITS;

  // Input synchronizers, reset to the idle-high bus level
  logic [SYNC_STAGES-1:0] sclPipe, sdaPipe;
  logic sclQ, sdaQ, sclS, sdaS;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclQ    <= 1'b1;
      sdaQ    <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[SYNC_STAGES-2:0], sclIn};
      sdaPipe <= {sdaPipe[SYNC_STAGES-2:0], sdaIn};
      sclQ    <= sclPipe[SYNC_STAGES-1];
      sdaQ    <= sdaPipe[SYNC_STAGES-1];
    end
  end

  assign sclS    = sclPipe[SYNC_STAGES-1];
  assign sdaS    = sdaPipe[SYNC_STAGES-1];
  assign evRise  = sclS & ~sclQ;
  assign evFall  = ~sclS & sclQ;
  assign evStart = sclS & sclQ & sdaQ & ~sdaS;
  assign evStop  = sclS & sclQ & ~sdaQ & sdaS;
  assign sdaNow  = sdaS;

  // Receive shifter
  logic [7:0] rxByte;

  always_ff @(posedge clk) begin
    if (!rstN)       rxByte <= '0;
    else if (evRise) rxByte <= {rxByte[6:0], sdaS};
  end

  assign rwBit = rxByte[0];

  // Select compare; enable bits below HI_BITS serve as address bits
  always_comb begin
    selMatch = (rxByte[7:4] == TYPE_ID);
    for (int k = 0; k < 3; k++) begin
      if (k >= HI_BITS && rxByte[k+1] != chipEn[k]) selMatch = 1'b0;
    end
  end

  // Address pointer, page staging buffer, transmit shifter, pad driver
  logic [ADDR_W-1:0] addrPtr;
  logic [7:0]        pageBuf [PAGE_LEN];
  logic [PAGE_LEN-1:0] pageVld;
  logic [7:0]        txShift;
  logic [7:0]        mem [DEPTH];
  logic [7:0]        memOut;
  logic [PAGE_BITS-1:0] pageOff;
  logic [TOP_W-1:0]  pageTop;

  assign memOut  = mem[addrPtr];
  assign pageOff = addrPtr[PAGE_BITS-1:0];
  assign pageTop = addrPtr[ADDR_W-1:PAGE_BITS];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrPtr <= '0;
      pageVld <= '0;
      txShift <= '0;
      sdaOe   <= 1'b0;
    end else begin
      if (strb.loadHi) begin
        for (int k = 0; k < HI_BITS; k++) addrPtr[8+k] <= rxByte[k+1];
      end
      if (strb.loadLo) addrPtr[7:0] <= rxByte;
      if (strb.stage) begin
        pageVld[pageOff] <= 1'b1;
        addrPtr[PAGE_BITS-1:0] <= pageOff + PAGE_BITS'(1);
      end
      if (strb.commit || strb.discard) pageVld <= '0;
      if (strb.loadTx) begin
        txShift <= memOut;
        addrPtr <= addrPtr + ADDR_W'(1);
      end
      if (strb.shiftTx) txShift <= {txShift[6:0], 1'b0};
      // pad driver
      if (strb.driveAck)     sdaOe <= 1'b1;
      else if (strb.letGo)   sdaOe <= 1'b0;
      else if (strb.loadTx)  sdaOe <= ~memOut[7];
      else if (strb.shiftTx) sdaOe <= ~txShift[6];
    end
  end

  always_ff @(posedge clk) begin
    if (strb.stage) pageBuf[pageOff] <= rxByte;
  end

  always_ff @(posedge clk) begin
    if (strb.commit) begin
      for (int i = 0; i < PAGE_LEN; i++) begin
        if (pageVld[i]) mem[{pageTop, PAGE_BITS'(i)}] <= pageBuf[i];
      end
    end
  end

endmodule

// File: rtl/sms_control.sv
module sms_control
  import sms_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    evStart,
  input  logic    evStop,
  input  logic    evRise,
  input  logic    evFall,
  input  logic    sdaNow,
  input  logic    rwBit,
  input  logic    selMatch,
  input  logic    wcIn,
  output strobe_t strb
);

  // bitCnt: 0..8 data bits seen, 9 = inside the acknowledge slot
  state_t     state, stN;
  logic [3:0] bitCnt, cntN;
  logic       gotData, gotN;

  always_comb begin
    strb = '0;
    stN  = state;
    cntN = bitCnt;
    gotN = gotData;
    if (evStart) begin
      strb.letGo   = 1'b1;
      strb.discard = 1'b1;
      stN  = ST_SEL;
      cntN = '0;
      gotN = 1'b0;
    end else if (evStop) begin
      strb.letGo = 1'b1;
      if (state == ST_DATA && gotData) strb.commit  = 1'b1;
      else                             strb.discard = 1'b1;
      stN  = ST_IDLE;
      cntN = '0;
      gotN = 1'b0;
    end else begin
      unique case (state)
        ST_SEL, ST_ADDR, ST_DATA: begin
          if (evRise && bitCnt < 4'd8) begin
            cntN = bitCnt + 4'd1;
          end else if (evFall && bitCnt == 4'd8) begin
            cntN = 4'd9;
            if (state == ST_SEL) begin
              if (selMatch) begin
                strb.driveAck = 1'b1;
                strb.loadHi   = 1'b1;
                stN = rwBit ? ST_READ : ST_ADDR;
              end else begin
                stN = ST_SKIP;
              end
            end else if (state == ST_ADDR) begin
              strb.driveAck = 1'b1;
              strb.loadLo   = 1'b1;
              stN = ST_DATA;
            end else if (!wcIn) begin
              strb.driveAck = 1'b1;
              strb.stage    = 1'b1;
              gotN = 1'b1;
            end
          end else if (evFall && bitCnt == 4'd9) begin
            strb.letGo = 1'b1;
            cntN = '0;
          end
        end
        ST_READ: begin
          if (evFall && bitCnt == 4'd9) begin
            strb.loadTx = 1'b1;
            cntN = '0;
          end else if (evRise && bitCnt < 4'd8) begin
            cntN = bitCnt + 4'd1;
          end else if (evFall && bitCnt >= 4'd1 && bitCnt <= 4'd7) begin
            strb.shiftTx = 1'b1;
          end else if (evFall && bitCnt == 4'd8) begin
            strb.letGo = 1'b1;
            cntN = 4'd9;
          end else if (evRise && bitCnt == 4'd9 && sdaNow) begin
            stN = ST_SKIP;
          end
        end
        ST_SKIP: begin
          if (evFall && bitCnt == 4'd9) begin
            strb.letGo = 1'b1;
            cntN = '0;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      bitCnt  <= '0;
      gotData <= 1'b0;
    end else begin
      state   <= stN;
      bitCnt  <= cntN;
      gotData <= gotN;
    end
  end

endmodule

// File: rtl/serial_mem_slave.sv
module serial_mem_slave
  import sms_pkg::*;
#(
  parameter int HI_BITS     = 0,
  parameter int PAGE_BITS   = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [2:0] chipEn,
  input  logic       wcIn,
  output logic       sdaOe
);

  strobe_t strb;
  logic evStart, evStop, evRise, evFall, sdaNow, rwBit, selMatch;

  sms_datapath #(
    .HI_BITS    (HI_BITS),
    .PAGE_BITS  (PAGE_BITS),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .sclIn   (sclIn),
    .sdaIn   (sdaIn),
    .chipEn  (chipEn),
    .strb    (strb),
    .evStart (evStart),
    .evStop  (evStop),
    .evRise  (evRise),
    .evFall  (evFall),
    .sdaNow  (sdaNow),
    .rwBit   (rwBit),
    .selMatch(selMatch),
    .sdaOe   (sdaOe)
  );

  sms_control u_ctl (
    .clk     (clk),
    .rstN    (rstN),
    .evStart (evStart),
    .evStop  (evStop),
    .evRise  (evRise),
    .evFall  (evFall),
    .sdaNow  (sdaNow),
    .rwBit   (rwBit),
    .selMatch(selMatch),
    .wcIn    (wcIn),
    .strb    (strb)
  );

endmodule

// File: rtl/sms_checker.sv
module sms_checker (
  input logic       clk,
  input logic       rstN,
  input logic       sdaOe,
  input logic       evStart,
  input logic       evStop,
  input logic       evFall,
  input logic [3:0] oeActs,
  input logic       commit,
  input logic       stage,
  input logic       wcIn
);

  // R11
  oe_after_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaOe) |-> $past(evFall | evStart | evStop));

  // R2
  stop_frees_line_chk: assert property (@(posedge clk) disable iff (!rstN)
    evStop |=> !sdaOe);

  // R9
  commit_at_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    commit |-> evStop);

  // R7
  protect_blocks_stage_chk: assert property (@(posedge clk) disable iff (!rstN)
    stage |-> !wcIn);

  // R5
  one_pad_action_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(oeActs));

endmodule

bind serial_mem_slave sms_checker u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .sdaOe  (sdaOe),
  .evStart(evStart),
  .evStop (evStop),
  .evFall (evFall),
  .oeActs ({strb.driveAck, strb.letGo, strb.loadTx, strb.shiftTx}),
  .commit (strb.commit),
  .stage  (strb.stage),
  .wcIn   (wcIn)
);

// File: tb/sim_serial_mem_slave.sv
module sim_serial_mem_slave;

  localparam int Q = 8;  // system clocks per quarter bit

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic mScl = 1'b1;
  logic mOe = 1'b0;
  logic wc = 1'b0;
  logic oe0, oe1;
  logic bus0, bus1;
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  assign bus0 = ~(mOe | oe0);
  assign bus1 = ~(mOe | oe1);

  serial_mem_slave #(.HI_BITS(0), .PAGE_BITS(4)) u0 (
    .clk(clk), .rstN(rstN), .sclIn(mScl), .sdaIn(bus0),
    .chipEn(3'b101), .wcIn(wc), .sdaOe(oe0));

  serial_mem_slave #(.HI_BITS(2), .PAGE_BITS(4)) u1 (
    .clk(clk), .rstN(rstN), .sclIn(mScl), .sdaIn(bus1),
    .chipEn(3'b110), .wcIn(wc), .sdaOe(oe1));

  // {target, select byte, expected ack}
  localparam logic [9:0] VEC [9] = '{
    {1'b0, 8'hAA, 1'b1},
    {1'b0, 8'hA8, 1'b0},
    {1'b0, 8'hBA, 1'b0},
    {1'b0, 8'h2A, 1'b0},
    {1'b0, 8'hA2, 1'b0},
    {1'b1, 8'hA8, 1'b1},
    {1'b1, 8'hAE, 1'b1},
    {1'b1, 8'hA4, 1'b0},
    {1'b1, 8'hBC, 1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic qWait();
    repeat (Q) @(negedge clk);
  endtask

  function automatic logic lineOf(input bit tgt);
    return tgt ? bus1 : bus0;
  endfunction

  task automatic busStart();
    mOe = 1'b0; qWait();
    mScl = 1'b1; qWait();
    mOe = 1'b1; qWait();
    mScl = 1'b0; qWait();
  endtask

  task automatic busStop();
    mOe = 1'b1; qWait();
    mScl = 1'b1; qWait();
    mOe = 1'b0; qWait();
  endtask

  task automatic sendByte(input bit tgt, input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      mOe = ~b[i]; qWait();
      mScl = 1'b1; qWait(); qWait();
      mScl = 1'b0; qWait();
    end
    mOe = 1'b0; qWait();
    mScl = 1'b1; qWait();
    ack = ~lineOf(tgt);
    qWait();
    mScl = 1'b0; qWait();
  endtask

  task automatic recvByte(input bit tgt, input logic giveAck, output logic [7:0] d);
    mOe = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      qWait();
      mScl = 1'b1; qWait();
      d[i] = lineOf(tgt);
      qWait();
      mScl = 1'b0; qWait();
    end
    mOe = giveAck; qWait();
    mScl = 1'b1; qWait(); qWait();
    mScl = 1'b0; qWait();
    mOe = 1'b0;
  endtask

  task automatic readAt(input bit tgt, input logic [7:0] sel, input logic [7:0] addr,
                        output logic [7:0] d);
    logic ack;
    busStart();
    sendByte(tgt, sel, ack);
    sendByte(tgt, addr, ack);
    busStart();
    sendByte(tgt, sel | 8'h01, ack);
    recvByte(tgt, 1'b0, d);
    busStop();
  endtask

  task automatic writeOne(input bit tgt, input logic [7:0] sel, input logic [7:0] addr,
                          input logic [7:0] data, output logic ackD);
    logic ack;
    busStart();
    sendByte(tgt, sel, ack);
    sendByte(tgt, addr, ack);
    sendByte(tgt, data, ackD);
    busStop();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic ack;
    logic [7:0] d;
    repeat (5) @(negedge clk);
    // R1 line quiet in reset
    check("R1 oe0 in reset", oe0, 1'b0);
    check("R1 oe1 in reset", oe1, 1'b0);
    rstN = 1'b1;
    repeat (10) @(negedge clk);
    check("R1 oe0 after reset", oe0, 1'b0);
    check("R1 oe1 after reset", oe1, 1'b0);

    // R3 R4 select vectors
    for (int v = 0; v < 9; v++) begin
      busStart();
      sendByte(VEC[v][9], VEC[v][8:1], ack);
      check($sformatf("R3/R4 select vector %0d", v), ack, VEC[v][0]);
      busStop();
    end

    // R3 mismatched type code stays silent on later bytes
    busStart();
    sendByte(1'b0, 8'hBA, ack);
    sendByte(1'b0, 8'h00, ack);
    check("R3 silent after mismatch", ack, 1'b0);
    busStop();

    // R5 R6 byte write, then R10 read back
    busStart();
    sendByte(1'b0, 8'hAA, ack);
    check("R5 select ack", ack, 1'b1);
    sendByte(1'b0, 8'h20, ack);
    check("R6 address ack", ack, 1'b1);
    sendByte(1'b0, 8'h5A, ack);
    check("R5 data ack", ack, 1'b1);
    busStop();
    readAt(1'b0, 8'hAA, 8'h20, d);
    check("R10 random read", d, 8'h5A);

    // R7 write protect
    wc = 1'b1;
    busStart();
    sendByte(1'b0, 8'hAA, ack);
    check("R6 select ack under protect", ack, 1'b1);
    sendByte(1'b0, 8'h20, ack);
    check("R6 address ack under protect", ack, 1'b1);
    sendByte(1'b0, 8'hFF, ack);
    check("R7 data nack first", ack, 1'b0);
    sendByte(1'b0, 8'hEE, ack);
    check("R7 data nack page", ack, 1'b0);
    busStop();
    wc = 1'b0;
    readAt(1'b0, 8'hAA, 8'h20, d);
    check("R7 memory unchanged", d, 8'h5A);

    // R9 repeated START discards staged data
    busStart();
    sendByte(1'b0, 8'hAA, ack);
    sendByte(1'b0, 8'h20, ack);
    sendByte(1'b0, 8'h77, ack);
    busStart();
    busStop();
    readAt(1'b0, 8'hAA, 8'h20, d);
    check("R9 repeated start discards", d, 8'h5A);

    // R8 page wrap: guard byte past the page first
    writeOne(1'b0, 8'hAA, 8'h40, 8'h11, ack);
    busStart();
    sendByte(1'b0, 8'hAA, ack);
    sendByte(1'b0, 8'h3E, ack);
    for (int i = 0; i < 18; i++) sendByte(1'b0, 8'h80 + 8'(i), ack);
    busStop();
    busStart();
    sendByte(1'b0, 8'hAA, ack);
    sendByte(1'b0, 8'h30, ack);
    busStart();
    sendByte(1'b0, 8'hAB, ack);
    for (int k = 0; k < 17; k++) begin
      recvByte(1'b0, k < 16, d);
      if (k < 16) check($sformatf("R8 wrapped byte %0d", k), d, 8'h82 + 8'(k));
      else        check("R8 upper bits fixed R10 pointer crosses page", d, 8'h11);
    end
    busStop();

    // R4 bank bits on the dense copy
    writeOne(1'b1, 8'hAC, 8'h05, 8'hC3, ack);
    check("R4 bank write ack", ack, 1'b1);
    writeOne(1'b1, 8'hAA, 8'h05, 8'h3C, ack);
    readAt(1'b1, 8'hAC, 8'h05, d);
    check("R4 bank 2 data", d, 8'hC3);
    readAt(1'b1, 8'hAA, 8'h05, d);
    check("R4 bank 1 data", d, 8'h3C);

    // R2 line released after stop
    repeat (10) @(negedge clk);
    check("R2 oe0 idle", oe0, 1'b0);
    check("R2 oe1 idle", oe1, 1'b0);

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule